// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit turns a process's program addresses into physical store addresses. It supports two addressing modes, and each access chooses its own mode, so one process can mix them freely. Both modes resolve through a per-process table of permitted segments. Trusted software loads this table through a write port.

In windowed mode the address is 16 bits wide. Its top two bits pick one of four window registers, and each window register names a table entry. In flat mode the address is 32 bits wide, and every 16KiB slice of it maps to the table entry whose index equals the slice number. Instruction fetch is legal only in windowed mode.

After reset the unit is in test mode. In test mode no mapping is done and only the bottom 64KiB of store can be reached. A single command moves the unit into protected mode, and only the operator reset can bring it back to test mode.

A request is registered on the clock edge. The response comes in the following cycle, translated combinationally from the registered request and the tables as they stand in that cycle.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `prot_mode` is 0, `rsp_valid` is 0, every table entry is invalid and every window register holds index 0.
- R2: In protected mode, a windowed access with address A uses window register A[15:14]. Its table entry E gives `rsp_paddr` = E.base*16384 + A[13:0].
- R3: In protected mode, a flat access with address A uses table entry A[31:14] and gives `rsp_paddr` = base*16384 + A[13:0].
- R4: In protected mode, a flat access that is an instruction fetch faults with cause 5. This cause takes priority over every other cause.
- R5: A windowed access through an invalid entry faults with cause 1. A flat access whose slice index is at least the table size (64), or whose entry is invalid, faults with cause 2.
- R6: An offset A[13:0] that is greater than or equal to the entry's byte length faults with cause 3. This check comes after the cause 1 and cause 2 checks.
- R7: A write to an entry whose write-enable bit is 0 faults with cause 4. Cause 4 has the lowest priority.
- R8: In test mode, a windowed access returns `rsp_paddr` = A[15:0] without any table lookup, and a flat access faults with cause 6.
- R9: A one-cycle pulse on `go_prot` sets `prot_mode` at the next edge. Later pulses have no effect, and only `rst_n` low clears the mode.
- R10: `rsp_valid` is `req_valid` delayed by one cycle. While `rsp_fault` is 1, `rsp_paddr` is 0 and `rsp_cause` is nonzero. Without a fault, `rsp_cause` is 0.
- R11: The mode of the unit applying to a request is the mode in force in the cycle the request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Operator reset, active low, asynchronous |
| go_prot | input | 1 | Command to switch into protected mode |
| tw_en | input | 1 | Table entry write strobe |
| tw_idx | input | 6 | Index of the table entry to write |
| tw_valid | input | 1 | Valid bit written to the entry |
| tw_base | input | 10 | Physical base in 16KiB units |
| tw_len | input | 15 | Segment length in bytes (0 to 16384) |
| tw_wr_ok | input | 1 | Write-enable bit written to the entry |
| ww_en | input | 1 | Window register write strobe |
| ww_sel | input | 2 | Window register to write |
| ww_idx | input | 6 | Table index loaded into the window register |
| req_valid | input | 1 | Request strobe |
| req_flat | input | 1 | 1 for a flat access, 0 for a windowed access |
| req_fetch | input | 1 | 1 for an instruction fetch |
| req_write | input | 1 | 1 for a data write |
| req_addr | input | 32 | Logical address (bits 31:16 ignored for windowed access) |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 24 | Physical address |
| rsp_fault | output | 1 | Protection fault |
| rsp_cause | output | 3 | Fault cause code |
| prot_mode | output | 1 | 1 once protected mode is entered |

## Verification
The assertions assume that `rst_n` is driven low before the first request and that no input carries X. They also assume that `go_prot` and `req_valid` are sampled only on clock edges. The bench changes every input on the falling edge and opens with a reset, so all of these hold.

The bench runs a behavioural model of the tables and the mode bit in step with the design. That model applies writes and the mode command at the same edge that captures a request, and it reads the mode as it stood before that edge. This matches the timing stated in R11.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int ENTRIES = 64,
  parameter int PA_W    = 24,
  localparam int IDXW   = $clog2(ENTRIES),
  localparam int SLICE  = 14,
  localparam int BASEW  = PA_W - SLICE,
  localparam int LENW   = SLICE + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_prot,
  input  logic             tw_en,
  input  logic [IDXW-1:0]  tw_idx,
  input  logic             tw_valid,
  input  logic [BASEW-1:0] tw_base,
  input  logic [LENW-1:0]  tw_len,
  input  logic             tw_wr_ok,
  input  logic             ww_en,
  input  logic [1:0]       ww_sel,
  input  logic [IDXW-1:0]  ww_idx,
  input  logic             req_valid,
  input  logic             req_flat,
  input  logic             req_fetch,
  input  logic             req_write,
  input  logic [31:0]      req_addr,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  output logic [2:0]       rsp_cause,
  output logic             prot_mode
);
  localparam int SLW = 32 - SLICE;
  localparam logic [SLW-1:0] ENT_LIM = SLW'(ENTRIES);
  localparam logic [2:0] C_OK = 3'd0, C_WIN = 3'd1, C_SLICE = 3'd2, C_LEN = 3'd3,
                         C_WP = 3'd4, C_FETCH = 3'd5, C_TEST = 3'd6;

  logic             ent_v  [ENTRIES];
  logic             ent_wr [ENTRIES];
  logic [BASEW-1:0] ent_base [ENTRIES];
  logic [LENW-1:0]  ent_len  [ENTRIES];
  logic [IDXW-1:0]  win [4];

  logic        r_flat, r_fetch, r_write, r_prot;
  logic [31:0] r_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_mode <= 1'b0;
      rsp_valid <= 1'b0;
      r_flat    <= 1'b0;
      r_fetch   <= 1'b0;
      r_write   <= 1'b0;
      r_prot    <= 1'b0;
      r_addr    <= '0;
      for (int i = 0; i < 4; i++) win[i] <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        ent_v[i]  <= 1'b0;
        ent_wr[i] <= 1'b0;
      end
    end else begin
      if (go_prot) prot_mode <= 1'b1;
      if (tw_en) begin
        ent_v[tw_idx]  <= tw_valid;
        ent_wr[tw_idx] <= tw_wr_ok;
      end
      if (ww_en) win[ww_sel] <= ww_idx;
      rsp_valid <= req_valid;
      if (req_valid) begin
        r_flat  <= req_flat;
        r_fetch <= req_fetch;
        r_write <= req_write;
        r_prot  <= prot_mode;
        r_addr  <= req_addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (tw_en) begin
      ent_base[tw_idx] <= tw_base;
      ent_len[tw_idx]  <= tw_len;
    end
  end

  wire [SLW-1:0]   slice_no  = r_addr[31:SLICE];
  wire             slice_oob = slice_no >= ENT_LIM;
  wire [SLICE-1:0] off       = r_addr[SLICE-1:0];
  wire [IDXW-1:0]  idx       = r_flat ? slice_no[IDXW-1:0] : win[r_addr[15:14]];

  logic [2:0] cause;
  always_comb begin
    cause = C_OK;
    if (!r_prot) begin
      if (r_flat) cause = C_TEST;
    end else if (r_flat && r_fetch)                     cause = C_FETCH;
    else if (r_flat && (slice_oob || !ent_v[idx]))      cause = C_SLICE;
    else if (!r_flat && !ent_v[idx])                    cause = C_WIN;
    else if ({1'b0, off} >= ent_len[idx])               cause = C_LEN;
    else if (r_write && !ent_wr[idx])                   cause = C_WP;
  end

  assign rsp_cause = rsp_valid ? cause : C_OK;
  assign rsp_fault = rsp_cause != C_OK;
  assign rsp_paddr = (!rsp_valid || rsp_fault) ? '0 :
                     r_prot ? {ent_base[idx], off} : PA_W'(r_addr[15:0]);

  p_oneway_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prot_mode |=> prot_mode);
  p_enter_r9: assert property (@(posedge clk) disable iff (!rst_n)
    go_prot |=> prot_mode);
  p_rsp_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_fault_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_paddr == '0 && rsp_valid));
  p_flat_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && r_prot && r_flat && r_fetch) |-> rsp_cause == C_FETCH);
  p_test_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !r_prot) |-> rsp_paddr[PA_W-1:16] == '0);
  p_test_flat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !r_prot && r_flat) |-> rsp_cause == C_TEST);
endmodule

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
  logic clk = 0, rst_n = 0;
  logic go_prot = 0, tw_en = 0, tw_valid = 0, tw_wr_ok = 0, ww_en = 0;
  logic [5:0] tw_idx = 0, ww_idx = 0;
  logic [9:0] tw_base = 0;
  logic [14:0] tw_len = 0;
  logic [1:0] ww_sel = 0;
  logic req_valid = 0, req_flat = 0, req_fetch = 0, req_write = 0;
  logic [31:0] req_addr = 0;
  logic rsp_valid, rsp_fault, prot_mode;
  logic [23:0] rsp_paddr;
  logic [2:0] rsp_cause;

  always #10 clk = ~clk;

  seg_xlate u_dut (.clk, .rst_n, .go_prot, .tw_en, .tw_idx, .tw_valid, .tw_base,
    .tw_len, .tw_wr_ok, .ww_en, .ww_sel, .ww_idx, .req_valid, .req_flat,
    .req_fetch, .req_write, .req_addr, .rsp_valid, .rsp_paddr, .rsp_fault,
    .rsp_cause, .prot_mode);

  int m_v[64], m_wr[64], m_base[64], m_len[64], m_win[4];
  int m_prot, e_valid, e_cause, e_pa;
  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prot = 0; e_valid = 0; e_cause = 0; e_pa = 0;
      foreach (m_v[i]) begin m_v[i] = 0; m_wr[i] = 0; end
      foreach (m_win[i]) m_win[i] = 0;
    end else begin
      int old_prot;
      old_prot = m_prot;
      if (go_prot) m_prot = 1;
      if (tw_en) begin
        m_v[tw_idx] = tw_valid; m_wr[tw_idx] = tw_wr_ok;
        m_base[tw_idx] = tw_base; m_len[tw_idx] = tw_len;
      end
      if (ww_en) m_win[ww_sel] = ww_idx;
      e_valid = req_valid;
      e_cause = 0; e_pa = 0;
      if (req_valid) begin
        longint a; int sl, ix, off;
        a = req_addr; off = int'(a % 16384); sl = int'(a / 16384);
        if (old_prot == 0) begin
          if (req_flat) e_cause = 6; else e_pa = int'(a % 65536);
        end else begin
          if (req_flat && req_fetch) e_cause = 5;
          else begin
            if (req_flat) begin
              ix = sl;
              if (sl >= 64) e_cause = 2; else if (m_v[ix] == 0) e_cause = 2;
            end else begin
              ix = m_win[sl % 4];
              if (m_v[ix] == 0) e_cause = 1;
            end
            if (e_cause == 0) begin
              if (off >= m_len[ix]) e_cause = 3;
              else if (req_write && m_wr[ix] == 0) e_cause = 4;
              else e_pa = m_base[ix] * 16384 + off;
            end
          end
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(tag, rsp_valid, e_valid, "rsp_valid (R10)");
    chk(tag, prot_mode, m_prot, "prot_mode (R9)");
    if (e_valid) begin
      chk(tag, rsp_cause, e_cause, "cause");
      chk(tag, rsp_fault, e_cause != 0, "fault");
      chk(tag, rsp_paddr, e_pa, "paddr");
    end
  end

  task automatic issue(bit flat, bit fetch, bit wr, logic [31:0] a);
    req_valid = 1; req_flat = flat; req_fetch = fetch; req_write = wr; req_addr = a;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic put_ent(int i, bit v, int base, int len, bit w);
    tw_en = 1; tw_idx = 6'(i); tw_valid = v; tw_base = 10'(base); tw_len = 15'(len); tw_wr_ok = w;
    @(negedge clk);
    tw_en = 0;
  endtask

  task automatic put_win(int s, int i);
    ww_en = 1; ww_sel = 2'(s); ww_idx = 6'(i);
    @(negedge clk);
    ww_en = 0;
  endtask

  task automatic pulse_go();
    go_prot = 1; @(negedge clk); go_prot = 0;
  endtask

  task automatic done();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    done();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R1";
    chk("R1", prot_mode, 0, "reset mode");
    chk("R1", rsp_valid, 0, "reset rsp_valid");
    tag = "R8";
    issue(0, 0, 0, 32'h0000_1234);
    issue(0, 1, 1, 32'hFFFF_C0DE);
    issue(1, 0, 0, 32'h0000_1234);
    @(negedge clk);
    // R11: request presented while go_prot pulses still sees test mode
    tag = "R11";
    go_prot = 1; req_valid = 1; req_flat = 0; req_fetch = 0; req_write = 0; req_addr = 32'h0000_ABCD;
    @(negedge clk);
    go_prot = 0; req_valid = 0;
    @(negedge clk);
    tag = "R2";
    put_ent(3, 1, 5, 16384, 1);
    put_ent(7, 1, 'h2A, 'h100, 0);
    put_ent(0, 1, 1, 16384, 1);
    put_ent(1, 1, 2, 'h2000, 1);
    put_ent(2, 0, 9, 16384, 1);
    put_win(0, 3); put_win(1, 7); put_win(2, 2); put_win(3, 0);
    issue(0, 0, 0, 32'h0000_0010);
    issue(0, 1, 0, 32'h0000_C123);
    issue(0, 0, 0, 32'h0000_40FF);
    tag = "R6";
    issue(0, 0, 0, 32'h0000_4100);
    tag = "R7";
    issue(0, 0, 1, 32'h0000_4010);
    issue(0, 0, 1, 32'h0000_0010);
    issue(0, 0, 1, 32'h0000_4200);
    tag = "R5";
    issue(0, 0, 0, 32'h0000_8000);
    issue(1, 0, 0, 32'h0000_8004);
    issue(1, 0, 0, 32'h0010_0000);
    issue(1, 0, 0, 32'hFFFF_FFFF);
    tag = "R3";
    issue(1, 0, 0, 32'h0000_4005);
    issue(1, 0, 1, 32'h0000_C777);
    issue(0, 0, 0, 32'h0000_0020);
    issue(1, 0, 0, 32'h0000_6000);
    tag = "R4";
    issue(1, 1, 0, 32'h0000_4005);
    issue(1, 1, 0, 32'h0010_0000);
    issue(0, 1, 0, 32'h0000_0004);
    tag = "R9";
    pulse_go();
    issue(0, 0, 0, 32'h0000_0010);
    tag = "R10";
    for (int k = 0; k < 400; k++) begin
      if (k % 7 == 0) put_ent(int'($urandom_range(0, 63)), 1'($urandom), int'($urandom_range(0, 1023)),
                              int'($urandom_range(0, 16384)), 1'($urandom));
      if (k % 11 == 0) put_win(int'($urandom_range(0, 3)), int'($urandom_range(0, 63)));
      if (k % 3 == 0) @(negedge clk);
      issue(1'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom),
            ($urandom_range(0, 1) == 1) ? {12'h0, 20'($urandom)} : $urandom);
    end
    @(negedge clk);
    tag = "R9";
    rst_n = 0;
    @(negedge clk);
    chk("R9", prot_mode, 0, "reset clears mode");
    rst_n = 1;
    @(negedge clk);
    issue(0, 0, 0, 32'h0000_C123);
    issue(1, 0, 0, 32'h0000_4005);
    repeat (2) @(negedge clk);
    done();
  end
endmodule